// File: doc/BRIEF.md
# Single-Cycle Six-Operation Processor Core

This block is a 32-bit processor that completes each instruction within one clock cycle. In every cycle it fetches a word from its own instruction store at the program counter and decodes it. It then reads two source registers, computes a result, and optionally accesses a separate data store. On the same rising edge it commits the register result and the next program counter. The core knows six operations: register add, register subtract, OR with a zero-extended immediate, word load, word store, and branch when two registers are equal. Any other encoding executes as a no-op.

The instruction store is filled through a preload stream before the core runs. That stream is valid/ready. `pl_ready` is high exactly while `rst` is high. A word moves only in a cycle where both `pl_valid` and `pl_ready` are high, so the core applies back-pressure for its entire run. A word offered while the core runs is never taken. A plain debug port reads any register combinationally. The program counter is visible on `pc_out`.

Top module: `six_op_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0. Reset is synchronous.
- R2: `pl_ready` equals `rst`. When `pl_valid` and `pl_ready` are both high at an edge, `pl_word` is stored at word `pl_addr` of the instruction store. When `pl_ready` is low, the offered word is dropped and the program is unchanged.
- R3: For opcode bits [31:26] = 0x00 with funct bits [5:0] = 0x21 (add) or 0x23 (subtract), register rd (bits [15:11]) receives rs (bits [25:21]) plus or minus rt (bits [20:16]). The result wraps modulo 2^32 and raises no trap.
- R4: Opcode 0x0D writes rs OR the zero-extended immediate (bits [15:0]) into register rt.
- R5: Opcode 0x23 loads the data word at byte address rs + sign-extended immediate into rt. The word index is the byte address divided by four.
- R6: Opcode 0x2B stores rt at byte address rs + sign-extended immediate. It writes no register, whatever bits [15:11] hold.
- R7: Opcode 0x04 sets the next program counter to PC+4+(sign-extended immediate × 4) when rs equals rt, and to PC+4 otherwise. A negative offset branches backwards.
- R8: Any other opcode, and opcode 0x00 with any funct other than 0x21 or 0x23, changes no register or data word and advances the program counter by 4.
- R9: Register 0 always reads as 0. A write that targets it is discarded.
- R10: `dbg_val` shows the register selected by `dbg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also opens the preload stream |
| pl_valid | input | 1 | Preload word offered |
| pl_ready | output | 1 | Preload word can be accepted (equals rst) |
| pl_addr | input | 6 | Instruction-store word index of the preload |
| pl_word | input | 32 | Instruction word to preload |
| dbg_sel | input | 5 | Register number to observe |
| dbg_val | output | 32 | Contents of the selected register |
| pc_out | output | 32 | Current program counter (byte address) |

## Verification
The case that is hardest to reach from the ports is a taken branch whose outcome depends on a value that went through the data store. Reaching it needs a negative store offset, a load back through the same offset, and an equality with a register computed by a wrapping subtract. The program builds that chain in order and then branches forward over two poisoning writes. It ends in a one-instruction backward loop, so the program counter freezes at a known value. While the core runs, a preload word is offered at the loop's address. This shows that back-pressure keeps the program intact, because the counter stays frozen and the poisoned register stays 0.

// File: rtl/six_op_pkg.sv
package six_op_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_sel_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     use_imm;
    logic     zext;
    logic     mem_rd;
    logic     mem_wr;
    logic     branch;
    alu_sel_e alu;
  } ctrl_t;
endpackage

// File: rtl/six_op_decode.sv
module six_op_decode
  import six_op_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl     = '0;
    ctrl.alu = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.reg_we = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.zext    = 1'b1;
        ctrl.alu     = ALU_OR;
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OPC_STOR: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu    = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/six_op_alu.sv
module six_op_alu
  import six_op_pkg::*;
(
  input  alu_sel_e          sel,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   y
);
  always_comb begin
    case (sel)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/six_op_regs.sv
module six_op_regs
  import six_op_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  sel_a,
  input  logic [RAW-1:0]  sel_b,
  input  logic [RAW-1:0]  sel_d,
  output logic [XLEN-1:0] val_a,
  output logic [XLEN-1:0] val_b,
  output logic [XLEN-1:0] val_d,
  input  logic            wen,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wen && waddr != '0) begin
      bank[waddr] <= wdata;
    end
  end

  assign val_a = (sel_a == '0) ? '0 : bank[sel_a];
  assign val_b = (sel_b == '0) ? '0 : bank[sel_b];
  assign val_d = (sel_d == '0) ? '0 : bank[sel_d];
endmodule

// File: rtl/six_op_core.sv
module six_op_core
  import six_op_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pl_valid,
  output logic            pl_ready,
  input  logic [IAW-1:0]  pl_addr,
  input  logic [31:0]     pl_word,
  input  logic [4:0]      dbg_sel,
  output logic [31:0]     dbg_val,
  output logic [31:0]     pc_out
);
  logic [XLEN-1:0] pc, pc_next, pc_seq, br_tgt;
  logic [31:0]     instr;
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, ld_data, wb_data;
  logic [RAW-1:0]  wa;
  logic            rf_we, take;
  logic [DAW-1:0]  dix;

  assign pl_ready = rst;

  always_ff @(posedge clk) begin
    if (pl_valid && pl_ready) imem[pl_addr] <= pl_word;
  end

  assign instr = imem[pc[IAW+1:2]];

  six_op_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign wa    = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we = ctrl.reg_we && !rst;

  six_op_regs u_rf (
    .clk   (clk),
    .rst   (rst),
    .sel_a (instr[25:21]),
    .sel_b (instr[20:16]),
    .sel_d (dbg_sel),
    .val_a (rs_val),
    .val_b (rt_val),
    .val_d (dbg_val),
    .wen   (rf_we),
    .waddr (wa),
    .wdata (wb_data)
  );

  assign imm_ext = ctrl.zext ? {16'h0000, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  six_op_alu u_alu (
    .sel (ctrl.alu),
    .a   (rs_val),
    .b   (alu_b),
    .y   (alu_y)
  );

  assign dix     = alu_y[DAW+1:2];
  assign ld_data = dmem[dix];

  always_ff @(posedge clk) begin
    if (ctrl.mem_wr && !rst) dmem[dix] <= rt_val;
  end

  assign wb_data = ctrl.mem_rd ? ld_data : alu_y;

  assign pc_seq  = pc + 32'd4;
  assign br_tgt  = pc_seq + {imm_ext[29:0], 2'b00};
  assign take    = ctrl.branch && (rs_val == rt_val);
  assign pc_next = take ? br_tgt : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign pc_out = pc;
endmodule

// File: rtl/six_op_checker.sv
module six_op_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        reg_we,
  input logic [4:0]  dbg_sel,
  input logic [31:0] dbg_val
);
  logic [5:0]  op;
  logic        legal;
  logic [31:0] tgt;

  assign op    = instr[31:26];
  assign legal = (op == 6'h0D) || (op == 6'h23) || (op == 6'h2B) || (op == 6'h04) ||
                 (op == 6'h00 && (instr[5:0] == 6'h21 || instr[5:0] == 6'h23));
  assign tgt   = pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};

  assert_pc_clear_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == 5'd0) |-> dbg_val == 32'd0);

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !legal |-> !reg_we);

  assert_seq_pc_R8: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04) |=> pc == $past(pc) + 32'd4);

  assert_branch_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=> pc == $past(tgt));

  assert_branch_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);
endmodule

bind six_op_core six_op_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (pc),
  .instr   (instr),
  .rs_val  (rs_val),
  .rt_val  (rt_val),
  .reg_we  (rf_we),
  .dbg_sel (dbg_sel),
  .dbg_val (dbg_val)
);

// File: tb/tb_six_op_core.sv
`timescale 1ns/1ps
module tb_six_op_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        pl_valid;
  logic        pl_ready;
  logic [5:0]  pl_addr;
  logic [31:0] pl_word;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_val;
  logic [31:0] pc_out;

  six_op_core dut (
    .clk(clk), .rst(rst), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_addr(pl_addr), .pl_word(pl_word), .dbg_sel(dbg_sel),
    .dbg_val(dbg_val), .pc_out(pc_out)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          idx;
    logic [31:0] val;
    string       req;
  } item_t;

  item_t pc_q[$];
  item_t rg_q[$];
  int n_chk = 0, n_bad = 0;
  bit run = 0, mon_done = 0, finished = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic push_pc(logic [31:0] v, string req);
    item_t it; it.idx = 0; it.val = v; it.req = req; pc_q.push_back(it);
  endtask

  task automatic push_reg(int r, logic [31:0] v, string req);
    item_t it; it.idx = r; it.val = v; it.req = req; rg_q.push_back(it);
  endtask

  task automatic preload(int a, logic [31:0] w);
    @(negedge clk);
    pl_valid = 1'b1; pl_addr = a[5:0]; pl_word = w;
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected items as the core produces them
  initial begin
    wait (run);
    while (pc_q.size() > 0) begin
      item_t it;
      @(negedge clk);
      it = pc_q.pop_front();
      check(it.req, "pc", pc_out, it.val);
    end
    while (rg_q.size() > 0) begin
      item_t it;
      it = rg_q.pop_front();
      dbg_sel = it.idx[4:0];
      #1;
      check(it.req, $sformatf("r%0d", it.idx), dbg_val, it.val);
    end
    mon_done = 1;
  end

  initial begin
    #(8 * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst = 1'b1; pl_valid = 1'b0; pl_addr = '0; pl_word = '0; dbg_sel = 5'd5;
    repeat (3) @(negedge clk);
    check("R1", "pc at reset", pc_out, 32'd0);
    check("R1", "r5 at reset", dbg_val, 32'd0);
    check("R2", "ready during reset", {31'd0, pl_ready}, 32'd1);

    preload(0,  enc_i(6'h0D, 0, 1, 16'h8005));      // R4 zero-extend
    preload(1,  enc_i(6'h0D, 0, 2, 16'h0003));
    preload(2,  enc_r(1, 2, 3, 6'h21));              // R3 add
    preload(3,  enc_r(2, 1, 4, 6'h23));              // R3 subtract wraps
    preload(4,  enc_i(6'h0D, 0, 5, 16'h0040));
    preload(5,  enc_i(6'h2B, 0, 3, 16'h0008));       // R6 store
    preload(6,  enc_i(6'h2B, 5, 4, 16'hFFF8));       // R6 store, bits[15:11]=31
    preload(7,  enc_i(6'h23, 5, 6, 16'hFFF8));       // R5 load negative offset
    preload(8,  enc_i(6'h23, 0, 7, 16'h0008));       // R5 load
    preload(9,  enc_i(6'h0D, 0, 0, 16'h1234));       // R9 write r0
    preload(10, enc_i(6'h3F, 0, 1, 16'hFFFF));       // R8 unknown opcode
    preload(11, enc_r(2, 2, 1, 6'h20));              // R8 unknown funct
    preload(12, enc_i(6'h04, 1, 2, 16'h0005));       // R7 not taken
    preload(13, enc_i(6'h04, 6, 4, 16'h0002));       // R7 taken forward
    preload(14, enc_i(6'h0D, 0, 9, 16'h0BAD));
    preload(15, enc_i(6'h0D, 0, 9, 16'h0BAD));
    preload(16, enc_i(6'h0D, 0, 10, 16'h0077));
    preload(17, enc_i(6'h04, 0, 0, 16'hFFFF));       // R7 backward self-loop

    for (int k = 1; k <= 13; k++) push_pc(32'(k * 4), "R8");
    push_pc(32'd64, "R7");
    push_pc(32'd68, "R7");
    for (int k = 0; k < 3; k++) push_pc(32'd68, "R2");

    push_reg(1,  32'h0000_8005, "R10");
    push_reg(2,  32'h0000_0003, "R4");
    push_reg(3,  32'h0000_8008, "R3");
    push_reg(4,  32'hFFFF_7FFE, "R3");
    push_reg(5,  32'h0000_0040, "R4");
    push_reg(6,  32'hFFFF_7FFE, "R5");
    push_reg(7,  32'h0000_8008, "R5");
    push_reg(0,  32'h0000_0000, "R9");
    push_reg(31, 32'h0000_0000, "R6");
    push_reg(9,  32'h0000_0000, "R7");
    push_reg(10, 32'h0000_0077, "R7");
    push_reg(11, 32'h0000_0000, "R2");
    push_reg(8,  32'h0000_0000, "R8");

    @(negedge clk);
    rst = 1'b0;
    run = 1;
    repeat (2) @(negedge clk);
    pl_valid = 1'b1; pl_addr = 6'd17; pl_word = enc_i(6'h0D, 0, 11, 16'h0055);
    #1;
    check("R2", "ready while running", {31'd0, pl_ready}, 32'd0);
    @(negedge clk);
    pl_valid = 1'b0;

    wait (mon_done);
    summary();
  end
endmodule